// File: doc/BRIEF.md
# Multi-Enable Interrupt Source Controller

The controller gathers a parameterised set of level-sensitive interrupt inputs and decides which of them may reach the processor. Each source can be gated by several enables at once. These are single bits in one or more mask registers and whole fields in one or more priority registers. A source counts as pending only while its input is high and every enable wired to it is active. Elaboration-time parameter arrays fix which bit or field belongs to which source, and which vector number each source returns.

Software reaches every register through a set address and, optionally, a clear address. Writing the set address ORs data into the register. Writing the clear address removes the bits that are 1 in the data. If a register has no clear address, writing its set address overwrites the register. Address matching looks only at the low 29 bits, so the upper three bits select an alias. A two-state machine raises the processor request while at least one source is pending: `IRQ_IDLE` goes to `IRQ_RAISED` when the pending set becomes non-empty, and `IRQ_RAISED` returns to `IRQ_IDLE` when it empties. In parallel, the lowest-numbered pending source is offered as the vector unless the processor mask level is 0xF.

Top module: `multi_enable_intc`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and `vec_valid_o` is 0.
- R2: A write to a register's set address, when that register also has a clear address, leaves the register equal to its old value OR the written data.
- R3: A write to a register's clear address leaves the register equal to its old value AND NOT the written data.
- R4: A register configured with clear address 0 has no clear address, and a write to its set address replaces its whole contents.
- R5: `rdata_o` shows the stored value of the register selected by either its set or its clear address, and shows 0 for an address that matches no register.
- R6: Register decoding compares only address bits 28:0, so bits 31:29 of `addr_i` are ignored.
- R7: Entry k of mask register r refers to bit REG_W-1-k, so entry 0 is the MSB. A source is pending only while its input is 1 and every mask bit mapped to it is 1.
- R8: Priority field k of a register occupies bits starting at (REG_W/FW-1-k)*FW. A mapped field enables its source only when its value is non-zero.
- R9: `irq_o` rises on the clock edge after the pending set becomes non-empty. It falls on the clock edge after the pending set becomes empty.
- R10: `vec_valid_o` is 0 while `imask_i` equals 0xF. Otherwise it is 1 exactly when some source is pending, and `vec_o` then carries the vector of the lowest-index pending source.
- R11: Source id 0 is reserved. It never becomes pending, whatever its input and the enables mapped to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 32 | Register address |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | REG_W | Write data |
| rdata_o | output | REG_W | Value of the addressed register |
| src_i | input | NSRC | Level interrupt inputs, bit i is source i |
| imask_i | input | 4 | Processor interrupt mask level |
| irq_o | output | 1 | Processor interrupt request |
| vec_valid_o | output | 1 | A vector is offered |
| vec_o | output | VW | Vector of the chosen source |

## Verification
The main stimulus is a cumulative sequence of set, clear and overwrite writes with every input held high. Some sources have a single enable and others have three. Each step records whether an incomplete set of enables wrongly yields a pending source, and which source the lowest-index rule selects when several are pending at once. Overwriting a priority register moves a non-zero value from one field to the other, which shows whether the field offsets are right. Writing 0x01 through the mask bit mapped to id 0 shows whether the reserved source is properly excluded. Directed cases then cover aliased addresses, dropping an input while its enables stay set, and the one-cycle delay of the request on both edges.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    localparam int unsigned PHYS_BITS = 29;

    // A reference address of 0 means "no such address".
    function automatic logic addr_hit(input logic [31:0] addr, input logic [31:0] ref_addr);
        return (ref_addr != 32'd0) && (addr[PHYS_BITS-1:0] == ref_addr[PHYS_BITS-1:0]);
    endfunction

endpackage

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_pkg::*;
#(
    parameter int NREG  = 3,
    parameter int REG_W = 8,
    parameter logic [NREG-1:0][31:0] SET_ADDR = '0,
    parameter logic [NREG-1:0][31:0] CLR_ADDR = '0
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [31:0]                 addr_i,
    input  logic                        wr_en_i,
    input  logic [REG_W-1:0]            wdata_i,
    output logic [NREG-1:0][REG_W-1:0]  regs_o,
    output logic [REG_W-1:0]            rdata_o
);

    logic [NREG-1:0] set_hit;
    logic [NREG-1:0] clr_hit;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam bit HAS_CLR = (CLR_ADDR[r] != 32'd0);

        assign set_hit[r] = addr_hit(addr_i, SET_ADDR[r]);
        assign clr_hit[r] = addr_hit(addr_i, CLR_ADDR[r]);

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                regs_o[r] <= '0;
            end else if (wr_en_i && set_hit[r]) begin
                if (HAS_CLR) regs_o[r] <= regs_o[r] | wdata_i;
                else         regs_o[r] <= wdata_i;
            end else if (wr_en_i && clr_hit[r]) begin
                regs_o[r] <= regs_o[r] & ~wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int r = 0; r < NREG; r++) begin
            if (set_hit[r] || clr_hit[r]) rdata_o = rdata_o | regs_o[r];
        end
    end

endmodule

// File: rtl/intc_enable_map.sv
module intc_enable_map #(
    parameter int NSRC  = 8,
    parameter int IDW   = 3,
    parameter int REG_W = 8,
    parameter int NMASK = 2,
    parameter int NPRIO = 1,
    parameter int FW    = 4,
    parameter logic [NMASK*REG_W-1:0][IDW-1:0]    MASK_MAP = '0,
    parameter logic [NPRIO*(REG_W/FW)-1:0][IDW-1:0] PRIO_MAP = '0
) (
    input  logic [NMASK+NPRIO-1:0][REG_W-1:0] regs_i,
    input  logic [NSRC-1:0]                   src_i,
    output logic [NSRC-1:0]                   pend_o
);

    localparam int NFLD = REG_W / FW;

    assign pend_o[0] = 1'b0;

    for (genvar s = 1; s < NSRC; s++) begin : g_src
        logic all_on;

        always_comb begin
            all_on = 1'b1;
            for (int j = 0; j < NMASK*REG_W; j++) begin
                if (MASK_MAP[j] == IDW'(s))
                    all_on = all_on & regs_i[j / REG_W][REG_W-1-(j % REG_W)];
            end
            for (int p = 0; p < NPRIO*NFLD; p++) begin
                if (PRIO_MAP[p] == IDW'(s))
                    all_on = all_on &
                        (|regs_i[NMASK + p / NFLD][(NFLD-1-(p % NFLD))*FW +: FW]);
            end
        end

        assign pend_o[s] = src_i[s] & all_on;
    end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int NSRC = 8,
    parameter int VW   = 8,
    parameter logic [NSRC-1:0][VW-1:0] VECTORS = '0
) (
    input  logic [NSRC-1:0] pend_i,
    input  logic [3:0]      imask_i,
    output logic            vec_valid_o,
    output logic [VW-1:0]   vec_o
);

    always_comb begin
        vec_o = '0;
        for (int i = NSRC-1; i >= 0; i--) begin
            if (pend_i[i]) vec_o = VECTORS[i];
        end
        vec_valid_o = (|pend_i) && (imask_i != 4'hF);
    end

endmodule

// File: rtl/multi_enable_intc.sv
module multi_enable_intc
    import intc_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int REG_W = 8,
    parameter int NMASK = 2,
    parameter int NPRIO = 1,
    parameter int FW    = 4,
    parameter int VW    = 8,
    localparam int IDW  = $clog2(NSRC),
    localparam int NREG = NMASK + NPRIO,
    localparam int NFLD = REG_W / FW,
    parameter logic [NMASK*REG_W-1:0][IDW-1:0] MASK_MAP = {
        3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd5, 3'd3,
        3'd0, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1},
    parameter logic [NPRIO*NFLD-1:0][IDW-1:0] PRIO_MAP = {3'd7, 3'd3},
    parameter logic [NSRC-1:0][VW-1:0] VECTORS = {
        8'h78, 8'h70, 8'h68, 8'h60, 8'h58, 8'h50, 8'h48, 8'h40},
    parameter logic [NREG-1:0][31:0] SET_ADDR = {32'h80, 32'h44, 32'h40},
    parameter logic [NREG-1:0][31:0] CLR_ADDR = {32'h00, 32'h64, 32'h60}
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [31:0]      addr_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    input  logic [NSRC-1:0]  src_i,
    input  logic [3:0]       imask_i,
    output logic             irq_o,
    output logic             vec_valid_o,
    output logic [VW-1:0]    vec_o
);

    logic [NREG-1:0][REG_W-1:0] regs;
    logic [NSRC-1:0]            pend;
    irq_state_e                 state_q, state_d;

    intc_regfile #(
        .NREG(NREG), .REG_W(REG_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)
    ) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wdata_i(wdata_i), .regs_o(regs), .rdata_o(rdata_o)
    );

    intc_enable_map #(
        .NSRC(NSRC), .IDW(IDW), .REG_W(REG_W), .NMASK(NMASK), .NPRIO(NPRIO),
        .FW(FW), .MASK_MAP(MASK_MAP), .PRIO_MAP(PRIO_MAP)
    ) u_map (
        .regs_i(regs), .src_i(src_i), .pend_o(pend)
    );

    intc_arbiter #(
        .NSRC(NSRC), .VW(VW), .VECTORS(VECTORS)
    ) u_arb (
        .pend_i(pend), .imask_i(imask_i), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
    );

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= IRQ_IDLE;
        else         state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (|pend)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (~|pend) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int REG_W = 8,
    parameter logic [31:0] SET0 = 32'h40,
    parameter logic [31:0] CLR0 = 32'h60
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [31:0]      addr_i,
    input logic             wr_en_i,
    input logic [REG_W-1:0] wdata_i,
    input logic [REG_W-1:0] reg0_i,
    input logic [NSRC-1:0]  pend_i,
    input logic [3:0]       imask_i,
    input logic             irq_o,
    input logic             vec_valid_o
);

    AST_SET_ORS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_hit(addr_i, SET0)) |=> ((reg0_i & $past(wdata_i)) == $past(wdata_i))); // R2

    AST_CLR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_hit(addr_i, CLR0) && !addr_hit(addr_i, SET0))
        |=> ((reg0_i & $past(wdata_i)) == '0)); // R3

    AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_valid_o |=> irq_o); // R9

    AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_o) |-> ($past(pend_i) == '0)); // R9

    AST_IRQ_STAYS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_o && pend_i == '0) |=> !irq_o); // R9

    AST_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (imask_i == 4'hF) |-> !vec_valid_o); // R10

endmodule

bind multi_enable_intc intc_checker #(
    .NSRC(NSRC), .REG_W(REG_W), .SET0(SET_ADDR[0]), .CLR0(CLR_ADDR[0])
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .reg0_i(regs[0]), .pend_i(pend), .imask_i(imask_i),
    .irq_o(irq_o), .vec_valid_o(vec_valid_o)
);

// File: tb/multi_enable_intc_tb.sv
module multi_enable_intc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  src = '0;
    logic [3:0]  imask = '0;
    logic        irq, vvalid;
    logic [7:0]  vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    multi_enable_intc u_dut (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .imask_i(imask),
        .irq_o(irq), .vec_valid_o(vvalid), .vec_o(vec)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [7:0]  d;
        logic [3:0]  m;
        logic        v;
        logic [7:0]  x;
        logic [7:0]  req;
    } step_t;

    // addr, data, imask, expected valid, expected vector, requirement tag
    localparam step_t STEPS [13] = '{
        '{32'h40, 8'h80, 4'h0, 1'b1, 8'h48, 8'd7},   // R7 src1 single enable
        '{32'h40, 8'h20, 4'h0, 1'b1, 8'h48, 8'd2},   // R2 src3 incomplete
        '{32'h60, 8'h80, 4'h0, 1'b0, 8'h00, 8'd3},   // R3
        '{32'h44, 8'h80, 4'h0, 1'b0, 8'h00, 8'd7},   // R7 src3 still lacks field
        '{32'h80, 8'h10, 4'h0, 1'b1, 8'h58, 8'd8},   // R8 field0 in bits 7:4
        '{32'h80, 8'h01, 4'h0, 1'b0, 8'h00, 8'd4},   // R4 replace moves to field1
        '{32'h40, 8'h02, 4'h0, 1'b1, 8'h78, 8'd8},   // R8 src7 via field1
        '{32'h40, 8'h01, 4'h0, 1'b1, 8'h78, 8'd11},  // R11 reserved bit
        '{32'h40, 8'h08, 4'h0, 1'b1, 8'h78, 8'd7},   // R7 src5 incomplete
        '{32'h44, 8'h40, 4'h0, 1'b1, 8'h68, 8'd10},  // R10 lowest index wins
        '{32'h40, 8'h00, 4'hF, 1'b0, 8'h00, 8'd10},  // R10 mask level F
        '{32'h64, 8'h40, 4'hE, 1'b1, 8'h78, 8'd3},   // R3
        '{32'h60, 8'hFF, 4'h0, 1'b0, 8'h00, 8'd3}    // R3 clear all
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [31:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [31:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 vec_valid", vvalid, 0);
        read_reg(32'h40, rd); check("R1 reg0", rd, 0);
        read_reg(32'h80, rd); check("R1 reg2", rd, 0);

        // Table walk, all inputs high
        src = 8'hFF;
        foreach (STEPS[i]) begin
            imask = STEPS[i].m;
            write_reg(STEPS[i].a, STEPS[i].d);
            check($sformatf("R%0d step %0d valid", STEPS[i].req, i), vvalid, STEPS[i].v);
            if (STEPS[i].v)
                check($sformatf("R%0d step %0d vector", STEPS[i].req, i), vec, STEPS[i].x);
        end
        imask = 4'h0;

        // R5 read through both addresses, unmapped reads 0
        read_reg(32'h44, rd); check("R5 set addr", rd, 8'h80);
        read_reg(32'h64, rd); check("R5 clr addr", rd, 8'h80);
        read_reg(32'h80, rd); check("R5 R4 plain reg", rd, 8'h01);
        read_reg(32'h50, rd); check("R5 unmapped", rd, 8'h00);
        @(negedge clk);
        check("R9 idle when empty", irq, 0);

        // R6 alias write, R9 rise timing
        write_reg(32'hE000_0040, 8'h40);
        check("R6 alias enables src2", vvalid, 1);
        check("R6 vector", vec, 8'h50);
        check("R9 irq not yet", irq, 0);
        @(negedge clk);
        check("R9 irq raised", irq, 1);
        read_reg(32'h2000_0060, rd); check("R6 alias read", rd, 8'h40);

        // R7 input drop, R9 fall timing
        src = 8'hFB;
        #1;
        check("R7 input low", vvalid, 0);
        check("R9 irq held", irq, 1);
        @(negedge clk);
        check("R9 irq released", irq, 0);

        // R11 reserved source
        src = 8'h01;
        write_reg(32'h40, 8'h01);
        check("R11 no vector", vvalid, 0);
        repeat (2) @(negedge clk);
        check("R11 no irq", irq, 0);
        read_reg(32'h40, rd); check("R11 R2 bit stored", rd, 8'h41);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule